// File: doc/BRIEF.md
# Tiled Surface Address Translator

This block turns a pixel coordinate on a 32-bit-per-pixel surface into the byte offset of that pixel from the start of the surface. It handles four memory layouts: plain row-major, a layout of 4 KiB tiles that are 512 bytes wide and 8 rows tall ("wide tiles"), a layout of 4 KiB tiles made of 16-byte columns 32 rows tall ("column tiles"), and a 4 KiB tile of 128 bytes by 32 rows whose 64-byte subtiles are stored in a permuted order ("subtile-permuted tiles"). For the two older tiled layouts an optional fold of higher address bits into bit 6 can be applied, as some memory controllers expect.

A request carries a valid strobe, the pixel column and row, the row pitch in bytes, a layout code and a fold-mode code. The unit accepts one request per clock with no stall and returns the offset three clocks later, together with a flag that marks a row pitch that is not a whole number of tiles for the selected layout. The offset is not defined when that flag is set.

Top module: `tile_addr_xlat`

## Requirements
- R1: With layout code 0 (row-major) the offset is y*pitch + 4*x, and the fold mode has no effect.
- R2: With layout code 1 (wide tiles, 512 bytes by 8 rows), with b = 4*x, the offset before folding is (y/8)*pitch*8 + (y%8)*512 + (b/512)*4096 + b%512.
- R3: With layout code 2 (column tiles, 16-byte columns, 32 rows), with b = 4*x, the offset before folding is (y/32)*pitch*32 + (y%32)*16 + (b/16)*512 + b%16.
- R4: With layout code 3 (subtile-permuted), with b = 4*x, c = b%128 and r = y%32, the offset is (y/32)*pitch*32 + (b/128)*4096 + s'*64 + (r%4)*16 + c%16, where s = (r/4)*8 + c/16 and s' is s with its bits 2 and 3 exchanged (so 4..7 become 8..11 and back).
- R5: With layout code 3 the fold mode never changes the offset.
- R6: For layout codes 1 and 2, fold code 1 XORs bit 9 of the unfolded offset into bit 6, code 2 XORs bits 9 and 10, code 3 XORs bits 9 and 11, code 4 XORs bits 9, 10 and 11, and code 0 leaves the offset unchanged; no bit other than bit 6 is ever altered.
- R7: A request accepted on one clock edge produces its result with the output valid asserted after exactly three clock edges; requests on consecutive cycles produce results on consecutive cycles, in order.
- R8: The pitch-error flag is set for layout 1 when pitch%512 is not 0, for layouts 2 and 3 when pitch%128 is not 0, and never for layout 0; it travels with its result.
- R9: A clock edge with the active-low reset asserted clears every valid flag in the pipeline, so no result from a request accepted before reset ever appears.
- R10: Fold codes 5, 6 and 7 behave as code 0.
- R11: Every offset produced is a multiple of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_x | input | X_W | Pixel column |
| req_y | input | Y_W | Pixel row |
| req_pitch | input | PITCH_W | Row pitch in bytes |
| req_layout | input | 2 | Layout code: 0 row-major, 1 wide tiles, 2 column tiles, 3 subtile-permuted |
| req_fold | input | 3 | Bit-6 fold mode code (0..4, 5..7 as 0) |
| rsp_valid | output | 1 | Result strobe, three cycles after the request |
| rsp_offset | output | OFS_W | Byte offset of the pixel |
| rsp_pitch_err | output | 1 | Pitch is not a whole number of tiles for the layout |

## Verification
On every cycle the assertions check the three-cycle valid latency against the request strobe, that reset empties each stage, that the fold stage touches no bit but bit 6 and passes the row-major and subtile-permuted offsets through untouched, that a row-major request never raises the pitch flag, and that outputs stay 4-byte aligned. The arithmetic of each layout, the subtile exchange, the exact bit combinations of each fold mode and the treatment of the spare fold codes can only be shown by the bench comparing offsets against its own model over chosen coordinates and a long back-to-back stream, as can the discarding of in-flight requests by a reset in mid-stream.

// File: rtl/tile_xlat_pkg.sv
// Shared types and small helpers for the tiled address translator.
// Assumes 4-byte pixels throughout.
package tile_xlat_pkg;

    typedef enum logic [1:0] {
        LAY_ROWMAJ = 2'd0,
        LAY_WIDE   = 2'd1,
        LAY_COLUMN = 2'd2,
        LAY_PERM   = 2'd3
    } layout_e;

    typedef enum logic [2:0] {
        FOLD_NONE     = 3'd0,
        FOLD_B9       = 3'd1,
        FOLD_B9_10    = 3'd2,
        FOLD_B9_11    = 3'd3,
        FOLD_B9_10_11 = 3'd4
    } fold_e;

    // Number of rows per tile, as a power of two, for the pitch multiply.
    function automatic logic [2:0] row_shift(layout_e lay);
        case (lay)
            LAY_WIDE:   return 3'd3;
            LAY_COLUMN: return 3'd5;
            LAY_PERM:   return 3'd5;
            default:    return 3'd0;
        endcase
    endfunction

    // Which of address bits 11..9 take part in the fold; [0] is bit 9.
    function automatic logic [2:0] fold_bits(logic [2:0] mode);
        case (mode)
            FOLD_B9:       return 3'b001;
            FOLD_B9_10:    return 3'b011;
            FOLD_B9_11:    return 3'b101;
            FOLD_B9_10_11: return 3'b111;
            default:       return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/tx_split.sv
// Stage 1: splits the coordinate into a row-block index and an in-row
// offset term for the selected layout. All divisions are by powers of
// two, so this is wiring, small adds and the subtile bit exchange.
// Assumes Y_W >= 5 and X_W >= 5.
module tx_split
    import tile_xlat_pkg::*;
#(
    parameter int X_W     = 14,
    parameter int Y_W     = 14,
    parameter int PITCH_W = 18,
    parameter int OFS_W   = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               v_in,
    input  logic [X_W-1:0]     x_in,
    input  logic [Y_W-1:0]     y_in,
    input  logic [PITCH_W-1:0] pitch_in,
    input  layout_e            lay_in,
    input  logic [2:0]         fold_in,
    output logic               v_out,
    output logic [Y_W-1:0]     rowblk_out,
    output logic [OFS_W-1:0]   low_out,
    output logic [PITCH_W-1:0] pitch_out,
    output layout_e            lay_out,
    output logic [2:0]         fold_out,
    output logic               err_out
);
    localparam int XB_W = X_W + 2;

    logic [XB_W-1:0]  xb;
    logic [5:0]       sub_idx;
    logic [5:0]       sub_perm;
    logic [11:0]      in_tile;
    logic [Y_W-1:0]   rowblk_c;
    logic [OFS_W-1:0] low_c;
    logic             err_c;

    assign xb = {x_in, 2'b00};

    // Subtile index inside a permuted tile and its bit-2/bit-3 exchange.
    always_comb begin
        sub_idx  = {y_in[4:2], xb[6:4]};
        sub_perm = {sub_idx[5:4], sub_idx[2], sub_idx[3], sub_idx[1:0]};
        in_tile  = {sub_perm, y_in[1:0], xb[3:0]};
    end

    // Per-layout row block and in-row offset term.
    always_comb begin
        case (lay_in)
            LAY_WIDE: begin
                rowblk_c = y_in >> 3;
                low_c    = (OFS_W'(xb >> 9) << 12) + (OFS_W'(y_in[2:0]) << 9)
                         + OFS_W'(xb[8:0]);
            end
            LAY_COLUMN: begin
                rowblk_c = y_in >> 5;
                low_c    = (OFS_W'(xb >> 4) << 9) + (OFS_W'(y_in[4:0]) << 4)
                         + OFS_W'(xb[3:0]);
            end
            LAY_PERM: begin
                rowblk_c = y_in >> 5;
                low_c    = (OFS_W'(xb >> 7) << 12) + OFS_W'(in_tile);
            end
            default: begin
                rowblk_c = y_in;
                low_c    = OFS_W'(xb);
            end
        endcase
    end

    // Pitch must hold a whole number of tiles for the tiled layouts.
    always_comb begin
        case (lay_in)
            LAY_WIDE:   err_c = |pitch_in[8:0];
            LAY_COLUMN: err_c = |pitch_in[6:0];
            LAY_PERM:   err_c = |pitch_in[6:0];
            default:    err_c = 1'b0;
        endcase
    end

    // Valid flag register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) v_out <= 1'b0;
        else        v_out <= v_in;
    end

    // Data registers; contents only matter while the valid flag is set.
    always_ff @(posedge clk) begin
        rowblk_out <= rowblk_c;
        low_out    <= low_c;
        pitch_out  <= pitch_in;
        lay_out    <= lay_in;
        fold_out   <= fold_in;
        err_out    <= err_c;
    end

    p_split_reset_r9: assert property (@(posedge clk) !rst_n |=> !v_out)
        else $error("split stage valid survived reset");

    p_rowmaj_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && lay_in == LAY_ROWMAJ) |=> (v_out && !err_out))
        else $error("row-major request flagged a pitch error");

endmodule

// File: rtl/tx_combine.sv
// Stage 2: multiplies the row-block index by the pitch, scales by the
// tile height and adds the in-row term, giving the unfolded offset.
// Assumes the product fits in OFS_W bits.
module tx_combine
    import tile_xlat_pkg::*;
#(
    parameter int Y_W     = 14,
    parameter int PITCH_W = 18,
    parameter int OFS_W   = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               v_in,
    input  logic [Y_W-1:0]     rowblk_in,
    input  logic [OFS_W-1:0]   low_in,
    input  logic [PITCH_W-1:0] pitch_in,
    input  layout_e            lay_in,
    input  logic [2:0]         fold_in,
    input  logic               err_in,
    output logic               v_out,
    output logic [OFS_W-1:0]   ofs_out,
    output layout_e            lay_out,
    output logic [2:0]         fold_out,
    output logic               err_out
);
    logic [OFS_W-1:0] prod;
    logic [OFS_W-1:0] sum_c;

    // Row-block base scaled by the tile height, plus the in-row term.
    always_comb begin
        prod  = OFS_W'(rowblk_in) * OFS_W'(pitch_in);
        sum_c = (prod << row_shift(lay_in)) + low_in;
    end

    // Valid flag register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) v_out <= 1'b0;
        else        v_out <= v_in;
    end

    // Data registers for the unfolded offset and its side information.
    always_ff @(posedge clk) begin
        ofs_out  <= sum_c;
        lay_out  <= lay_in;
        fold_out <= fold_in;
        err_out  <= err_in;
    end

    p_combine_reset_r9: assert property (@(posedge clk) !rst_n |=> !v_out)
        else $error("combine stage valid survived reset");

endmodule

// File: rtl/tx_fold.sv
// Stage 3: optionally XORs a chosen set of address bits 9..11 into
// bit 6 for the wide and column tiled layouts. The fold reads only the
// unfolded offset. Assumes OFS_W >= 12.
module tx_fold
    import tile_xlat_pkg::*;
#(
    parameter int OFS_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_in,
    input  logic [OFS_W-1:0] ofs_in,
    input  layout_e          lay_in,
    input  logic [2:0]       fold_in,
    input  logic             err_in,
    output logic             v_out,
    output logic [OFS_W-1:0] ofs_out,
    output logic             err_out
);
    localparam int NFOLD   = 3;
    localparam int FOLD_LO = 9;
    localparam int DST_BIT = 6;

    logic [NFOLD-1:0] en;
    logic [NFOLD-1:0] term;
    logic             fold_bit;
    logic [OFS_W-1:0] folded;

    // Fold applies only to the wide and column layouts.
    always_comb begin
        if (lay_in == LAY_WIDE || lay_in == LAY_COLUMN) en = fold_bits(fold_in);
        else                                            en = '0;
    end

    for (genvar k = 0; k < NFOLD; k++) begin : g_fold
        assign term[k] = en[k] & ofs_in[FOLD_LO + k];
    end

    // Combine the selected bits and flip bit 6.
    always_comb begin
        fold_bit = ^term;
        folded   = ofs_in ^ (OFS_W'(fold_bit) << DST_BIT);
    end

    // Valid flag register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) v_out <= 1'b0;
        else        v_out <= v_in;
    end

    // Output data registers.
    always_ff @(posedge clk) begin
        ofs_out <= folded;
        err_out <= err_in;
    end

    p_fold_reset_r9: assert property (@(posedge clk) !rst_n |=> !v_out)
        else $error("fold stage valid survived reset");

    p_only_bit6_r6: assert property (@(posedge clk) disable iff (!rst_n)
        v_in |=> ((ofs_out ^ $past(ofs_in)) & ~(OFS_W'(1) << DST_BIT)) == '0)
        else $error("fold altered a bit other than bit 6");

    p_no_fold_perm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && (lay_in == LAY_PERM || lay_in == LAY_ROWMAJ)) |=> ofs_out == $past(ofs_in))
        else $error("offset changed for a layout that must not fold (R1/R5)");

endmodule

// File: rtl/tile_addr_xlat.sv
// Top of the tiled address translator: three register stages (split,
// combine, fold), one request per cycle, fixed three-cycle latency,
// no backpressure. Assumes 4-byte pixels and a pitch that is a whole
// number of tiles; otherwise the offset is undefined and flagged.
module tile_addr_xlat
    import tile_xlat_pkg::*;
#(
    parameter int X_W     = 14,
    parameter int Y_W     = 14,
    parameter int PITCH_W = 18,
    parameter int OFS_W   = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [X_W-1:0]     req_x,
    input  logic [Y_W-1:0]     req_y,
    input  logic [PITCH_W-1:0] req_pitch,
    input  logic [1:0]         req_layout,
    input  logic [2:0]         req_fold,
    output logic               rsp_valid,
    output logic [OFS_W-1:0]   rsp_offset,
    output logic               rsp_pitch_err
);
    logic               s1_v, s2_v;
    logic [Y_W-1:0]     s1_rowblk;
    logic [OFS_W-1:0]   s1_low, s2_ofs;
    logic [PITCH_W-1:0] s1_pitch;
    layout_e            s1_lay, s2_lay;
    logic [2:0]         s1_fold, s2_fold;
    logic               s1_err, s2_err;

    tx_split #(.X_W(X_W), .Y_W(Y_W), .PITCH_W(PITCH_W), .OFS_W(OFS_W)) u_split (
        .clk(clk), .rst_n(rst_n),
        .v_in(req_valid), .x_in(req_x), .y_in(req_y), .pitch_in(req_pitch),
        .lay_in(layout_e'(req_layout)), .fold_in(req_fold),
        .v_out(s1_v), .rowblk_out(s1_rowblk), .low_out(s1_low),
        .pitch_out(s1_pitch), .lay_out(s1_lay), .fold_out(s1_fold), .err_out(s1_err)
    );

    tx_combine #(.Y_W(Y_W), .PITCH_W(PITCH_W), .OFS_W(OFS_W)) u_combine (
        .clk(clk), .rst_n(rst_n),
        .v_in(s1_v), .rowblk_in(s1_rowblk), .low_in(s1_low), .pitch_in(s1_pitch),
        .lay_in(s1_lay), .fold_in(s1_fold), .err_in(s1_err),
        .v_out(s2_v), .ofs_out(s2_ofs), .lay_out(s2_lay), .fold_out(s2_fold),
        .err_out(s2_err)
    );

    tx_fold #(.OFS_W(OFS_W)) u_fold (
        .clk(clk), .rst_n(rst_n),
        .v_in(s2_v), .ofs_in(s2_ofs), .lay_in(s2_lay), .fold_in(s2_fold),
        .err_in(s2_err),
        .v_out(rsp_valid), .ofs_out(rsp_offset), .err_out(rsp_pitch_err)
    );

    // Cycles since reset, saturating, so the latency check never looks
    // back past reset.
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n)            warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (rsp_valid == $past(req_valid, 3)))
        else $error("result valid does not follow request by three cycles");

    p_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_pitch_err) |-> (rsp_offset[1:0] == 2'b00))
        else $error("offset not 4-byte aligned");

endmodule

// File: tb/tile_addr_xlat_test.sv
module tile_addr_xlat_test;
    localparam int X_W = 14, Y_W = 14, PITCH_W = 18, OFS_W = 40;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic [X_W-1:0]     req_x = '0;
    logic [Y_W-1:0]     req_y = '0;
    logic [PITCH_W-1:0] req_pitch = '0;
    logic [1:0]         req_layout = '0;
    logic [2:0]         req_fold = '0;
    logic               rsp_valid;
    logic [OFS_W-1:0]   rsp_offset;
    logic               rsp_pitch_err;

    tile_addr_xlat #(.X_W(X_W), .Y_W(Y_W), .PITCH_W(PITCH_W), .OFS_W(OFS_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_x(req_x), .req_y(req_y),
        .req_pitch(req_pitch), .req_layout(req_layout), .req_fold(req_fold),
        .rsp_valid(rsp_valid), .rsp_offset(rsp_offset), .rsp_pitch_err(rsp_pitch_err)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    longint exp_ofs_q[$];
    bit     exp_err_q[$];
    bit     chk_ofs_q[$];
    int     exp_cyc_q[$];
    string  tag_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    // Reference model built from the requirement formulas.
    function automatic longint ref_ofs(longint x, longint y, longint p, int lay, int fold);
        longint b, v, c, r, s, sp;
        bit f;
        b = x * 4;
        case (lay)
            0: v = y * p + b;
            1: v = (y / 8) * p * 8 + (y % 8) * 512 + (b / 512) * 4096 + b % 512;
            2: v = (y / 32) * p * 32 + (y % 32) * 16 + (b / 16) * 512 + b % 16;
            default: begin
                c = b % 128; r = y % 32;
                s = (r / 4) * 8 + c / 16;
                sp = s;
                if (s % 16 >= 4 && s % 16 < 8)       sp = s + 4;
                else if (s % 16 >= 8 && s % 16 < 12) sp = s - 4;
                v = (y / 32) * p * 32 + (b / 128) * 4096 + sp * 64 + (r % 4) * 16 + c % 16;
            end
        endcase
        if (lay == 1 || lay == 2) begin
            f = 1'b0;
            if (fold >= 1 && fold <= 4)  f = v[9];
            if (fold == 2 || fold == 4)  f = f ^ v[10];
            if (fold == 3 || fold == 4)  f = f ^ v[11];
            v[6] = v[6] ^ f;
        end
        return v;
    endfunction

    function automatic bit ref_err(longint p, int lay);
        if (lay == 1) return (p % 512) != 0;
        if (lay == 2 || lay == 3) return (p % 128) != 0;
        return 1'b0;
    endfunction

    task automatic check(bit ok, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Driver: presents one request for one cycle and records its expectation.
    task automatic send(int x, int y, int p, int lay, int fold, string tag);
        req_valid  = 1'b1;
        req_x      = X_W'(x);
        req_y      = Y_W'(y);
        req_pitch  = PITCH_W'(p);
        req_layout = 2'(lay);
        req_fold   = 3'(fold);
        exp_err_q.push_back(ref_err(p, lay));
        chk_ofs_q.push_back(!ref_err(p, lay));
        exp_ofs_q.push_back(ref_ofs(x, y, p, lay, fold));
        exp_cyc_q.push_back(cyc + 3);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 20 && exp_ofs_q.size() != 0; i++) @(negedge clk);
        check(exp_ofs_q.size() == 0, "R7 results missing", exp_ofs_q.size(), 0);
    endtask

    // Monitor: pops and compares each result as it appears.
    always @(negedge clk) begin
        if (rst_n && rsp_valid && !done) begin
            if (exp_ofs_q.size() == 0) begin
                check(1'b0, "R7 unexpected result", rsp_offset, 0);
            end else begin
                longint eo; bit ee; bit co; int ec; string t;
                eo = exp_ofs_q.pop_front(); ee = exp_err_q.pop_front();
                co = chk_ofs_q.pop_front(); ec = exp_cyc_q.pop_front();
                t  = tag_q.pop_front();
                check(cyc == ec, {"R7 latency ", t}, cyc, ec);
                check(rsp_pitch_err == ee, {"R8 pitch flag ", t}, rsp_pitch_err, ee);
                if (co) check(rsp_offset == OFS_W'(eo), {"offset ", t}, rsp_offset, eo);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lcg;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check(rsp_valid == 1'b0, "R9 idle after reset", rsp_valid, 0);
        end

        // R1 row-major, fold ignored
        send(0, 0, 2048, 0, 0, "R1 origin");
        send(37, 5, 2048, 0, 4, "R1 fold ignored");
        send(511, 31, 4096, 0, 1, "R1 far pixel");
        // R2 wide tiles with each fold mode
        send(130, 11, 1024, 1, 0, "R2 plain");
        send(200, 3, 2048, 1, 1, "R2 R6 fold9");
        send(255, 7, 2048, 1, 2, "R2 R6 fold9_10");
        send(129, 6, 2048, 1, 3, "R2 R6 fold9_11");
        send(250, 14, 2048, 1, 4, "R2 R6 fold9_10_11");
        // R3 column tiles
        send(5, 33, 512, 2, 0, "R3 plain");
        send(100, 17, 1024, 2, 1, "R3 R6 fold9");
        send(77, 40, 1024, 2, 2, "R3 R6 fold9_10");
        send(63, 63, 2048, 2, 3, "R3 R6 fold9_11");
        send(255, 30, 2048, 2, 4, "R3 R6 fold9_10_11");
        // R4 subtile exchange 4..7 <-> 8..11 and untouched indices
        send(20, 1, 512, 3, 0, "R4 sub5 to 9");
        send(4, 4, 512, 3, 0, "R4 sub9 to 5");
        send(0, 0, 512, 3, 0, "R4 sub0");
        send(31, 31, 512, 3, 0, "R4 sub63");
        send(70, 45, 1024, 3, 0, "R4 second tile row");
        // R5 fold ignored for permuted layout
        send(20, 9, 512, 3, 4, "R5 fold ignored");
        send(52, 26, 1024, 3, 1, "R5 fold9 ignored");
        // R10 spare fold codes behave as none
        send(200, 3, 2048, 1, 5, "R10 code5");
        send(100, 17, 1024, 2, 7, "R10 code7");
        // R8 pitch flag
        send(3, 3, 640, 1, 0, "R8 wide bad pitch");
        send(3, 3, 640, 2, 0, "R8 column good pitch");
        send(3, 3, 600, 3, 0, "R8 permuted bad pitch");
        send(3, 3, 600, 0, 0, "R8 row-major never flagged");
        drain();

        // R7 R11 back-to-back stream
        lcg = 12345;
        for (int i = 0; i < 200; i++) begin
            int p, x, y;
            lcg = lcg * 1103515245 + 12345;
            p = 512 << ((lcg >>> 8) & 3);
            x = ((lcg >>> 12) & 32'h7fff) % (p / 4);
            y = (lcg >>> 4) & 255;
            send(x, y, p, i % 4, (i / 4) % 8, "R7 stream");
        end
        drain();

        // R9 reset while requests are in flight
        send(10, 10, 1024, 1, 1, "R9 in flight");
        send(11, 10, 1024, 2, 2, "R9 in flight");
        rst_n = 1'b0;
        exp_ofs_q.delete(); exp_err_q.delete(); chk_ofs_q.delete();
        exp_cyc_q.delete(); tag_q.delete();
        @(negedge clk);
        check(rsp_valid == 1'b0, "R9 flushed by reset", rsp_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check(rsp_valid == 1'b0, "R9 nothing after reset", rsp_valid, 0);
        end
        send(9, 9, 1024, 2, 0, "R9 after reset");
        drain();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule